// File: doc/BRIEF.md
# Four-Mode Floating-Point Rounding Stage

This block is the last stage of a double-precision multiply datapath. An upstream stage hands it a sign, a biased exponent and a 56-bit mantissa word. That word holds, from the top down: a spare carry bit that is always zero on input, the leading (hidden) bit, 52 fraction bits, a guard bit and a sticky bit. The stage narrows this word to 52 fraction bits under one of four rounding directions. It fixes up the exponent when the increment ripples past the leading bit or turns a subnormal into a normal. It then packs sign, exponent and fraction into a 64-bit word and flags inexact and overflow results.

The stage is one register deep. An input accompanied by `in_valid` appears on the outputs on the next clock edge, flagged by `out_valid`. Inputs presented without `in_valid` leave the outputs unchanged. Generating NaN and infinity for special-value operands is the job of a neighbouring block. This block only produces infinity or the largest finite value when its own exponent reaches the all-ones code.

Top module: `fp_round_unit`

## Requirements
- R1: With `in_mode` = 2'b00 (nearest, ties to even), the fraction is incremented exactly when guard = 1 and (sticky = 1 or fraction LSB = 1).
- R2: With `in_mode` = 2'b01 (toward zero), the fraction and exponent are passed through unchanged whatever guard and sticky are.
- R3: With `in_mode` = 2'b10 (toward +infinity), the fraction is incremented exactly when the sign is 0 and guard or sticky is 1.
- R4: With `in_mode` = 2'b11 (toward -infinity), the fraction is incremented exactly when the sign is 1 and guard or sticky is 1.
- R5: When the increment carries into mantissa bit 55, the mantissa is shifted right by one and the exponent rises by one.
- R6: An input with exponent 0 whose rounding sets the leading bit (bit 54) leaves with exponent 1. Without that carry, exponent 0 is kept.
- R7: `out_inexact` is 1 when guard or sticky is 1, or when overflow is reported; otherwise 0.
- R8: When the final exponent reaches 2047, `out_overflow` is 1. In mode 00, mode 10 with sign 0, or mode 11 with sign 1, the result is infinity (exponent 2047, fraction 0).
- R9: On overflow in mode 01, mode 10 with sign 1, or mode 11 with sign 0, the result is the largest finite value (exponent 2046, fraction all ones).
- R10: Results appear one cycle after `in_valid`, with `out_valid` high for exactly that cycle. Without `in_valid` the outputs hold. Reset clears `out_valid`, `out_result` and both flags.
- R11: The result is packed as {sign at bit 63, exponent at bits 62:52, fraction at bits 51:0}, and the sign equals `in_sign`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_sign | input | 1 | Result sign |
| in_exp | input | 11 | Biased exponent before rounding |
| in_mant | input | 56 | {carry 0, leading bit, 52 fraction bits, guard, sticky} |
| in_mode | input | 2 | Rounding direction: 00 nearest-even, 01 zero, 10 +inf, 11 -inf |
| out_valid | output | 1 | Result is valid this cycle |
| out_result | output | 64 | Packed rounded result |
| out_inexact | output | 1 | Precision was lost |
| out_overflow | output | 1 | Exponent reached the all-ones code |

## Verification
Every result, flag and `out_valid` is due exactly one rising edge after the edge that samples `in_valid`. The bench drives each input on a falling edge, lets one rising edge pass, and samples at the next falling edge, away from the edge that updates the register. Hold behaviour is checked on the cycle after an idle input. Back-to-back inputs are checked on consecutive falling edges, so each result is seen in its own single-cycle window.

// File: rtl/fp_rnd_pkg.sv
package fp_rnd_pkg;
  // Rounding direction codes carried on the mode input.
  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_ZERO      = 2'b01,
    RND_POS       = 2'b10,
    RND_NEG       = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/fp_rnd_decide.sv
// Decides whether the kept fraction must be bumped by one ulp, and whether
// the selected direction points toward zero for this sign (used on overflow).
module fp_rnd_decide
  import fp_rnd_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       sign,
  input  logic       lsb,
  input  logic       guard,
  input  logic       sticky,
  output logic       inc,
  output logic       toward_zero
);
  logic lost;

  always_comb begin
    lost = guard | sticky;
    case (rnd_mode_e'(mode))
      RND_NEAR_EVEN: begin  // R1: ties go to the even neighbour
        inc         = guard & (sticky | lsb);
        toward_zero = 1'b0;
      end
      RND_ZERO: begin       // R2
        inc         = 1'b0;
        toward_zero = 1'b1;
      end
      RND_POS: begin        // R3
        inc         = ~sign & lost;
        toward_zero = sign;
      end
      default: begin        // RND_NEG, R4
        inc         = sign & lost;
        toward_zero = ~sign;
      end
    endcase
  end
endmodule

// File: rtl/fp_rnd_adjust.sv
// Applies the increment, renormalises on carry, promotes subnormals and
// saturates on exponent overflow. Output is the packed word.
module fp_rnd_adjust #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                    sign,
  input  logic [EXP_W-1:0]        exp_in,
  input  logic [FRAC_W+1:0]       mant_hi,   // {carry, leading, fraction}
  input  logic                    inc,
  input  logic                    toward_zero,
  output logic [EXP_W+FRAC_W:0]   packed_res,
  output logic                    overflow
);
  localparam int          SUM_W   = FRAC_W + 2;
  localparam logic [EXP_W:0] EXP_TOP = {1'b0, {EXP_W{1'b1}}};

  logic [SUM_W-1:0]  sum;
  logic              carry;
  logic [FRAC_W-1:0] frac;
  logic [EXP_W:0]    exp_w;

  always_comb begin
    sum   = mant_hi + {{(SUM_W-1){1'b0}}, inc};
    carry = sum[SUM_W-1];
    // R5: carry past the leading bit -> shift right one, exponent + 1
    frac  = carry ? sum[FRAC_W:1] : sum[FRAC_W-1:0];
    exp_w = {1'b0, exp_in} + {{EXP_W{1'b0}}, carry};
    // R6: subnormal that gained a leading one becomes the smallest normal
    if (!carry && (exp_in == '0) && sum[FRAC_W])
      exp_w = {{EXP_W{1'b0}}, 1'b1};
    overflow = (exp_w >= EXP_TOP);
    if (overflow) begin
      if (toward_zero)   // R9: largest finite value
        packed_res = {sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
      else               // R8: infinity
        packed_res = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else begin
      packed_res = {sign, exp_w[EXP_W-1:0], frac};
    end
  end
endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit
  import fp_rnd_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int MANT_W = FRAC_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0] in_mant,
  input  logic [1:0]        in_mode,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_result,
  output logic              out_inexact,
  output logic              out_overflow
);
  logic              inc;
  logic              tz;
  logic [WORD_W-1:0] res_c;
  logic              ovf_c;
  logic              ix_c;

  fp_rnd_decide u_decide (
    .mode        (in_mode),
    .sign        (in_sign),
    .lsb         (in_mant[2]),
    .guard       (in_mant[1]),
    .sticky      (in_mant[0]),
    .inc         (inc),
    .toward_zero (tz)
  );

  fp_rnd_adjust #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_adjust (
    .sign        (in_sign),
    .exp_in      (in_exp),
    .mant_hi     (in_mant[MANT_W-1:2]),
    .inc         (inc),
    .toward_zero (tz),
    .packed_res  (res_c),
    .overflow    (ovf_c)
  );

  // R7: lost bits or saturation make the result inexact
  assign ix_c = in_mant[1] | in_mant[0] | ovf_c;

  // R10: single output register stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_inexact  <= 1'b0;
      out_overflow <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result   <= res_c;
        out_inexact  <= ix_c;
        out_overflow <= ovf_c;
      end
    end
  end

  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> (out_result == $past(out_result)));

  assert_sign_pass_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid)) |-> (out_result[WORD_W-1] == $past(in_sign)));

  assert_overflow_inexact_R7: assert property (@(posedge clk) disable iff (rst)
    out_overflow |-> out_inexact);

  assert_overflow_exp_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_overflow) |->
      (out_result[WORD_W-2 -: EXP_W] == {EXP_W{1'b1}} ||
       out_result[WORD_W-2 -: EXP_W] == {{(EXP_W-1){1'b1}}, 1'b0}));

  assert_truncate_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(in_mode) == RND_ZERO && !out_overflow) |->
      (out_result[WORD_W-2:0] == {$past(in_exp), $past(in_mant[MANT_W-3:2])}));
endmodule

// File: tb/fp_round_unit_tb_top.sv
`timescale 1ns/1ps
module fp_round_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_sign = 1'b0;
  logic [10:0] in_exp = '0;
  logic [55:0] in_mant = '0;
  logic [1:0]  in_mode = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_inexact;
  logic        out_overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fp_round_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_mant(in_mant), .in_mode(in_mode),
    .out_valid(out_valid), .out_result(out_result),
    .out_inexact(out_inexact), .out_overflow(out_overflow)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        sign;
    logic [10:0] exp;
    logic        lead;
    logic [51:0] frac;
    logic [1:0]  gs;
    logic [10:0] e_exp;
    logic [51:0] e_frac;
    logic        e_ix;
    logic        e_ov;
    logic [7:0]  req;
  } vec_t;

  localparam logic [51:0] ONES = 52'hFFFFFFFFFFFFF;
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'b00,1'b0,11'd1023,1'b1,52'h0,2'b10,11'd1023,52'h0,1'b1,1'b0,8'd1},     // R1 tie, even kept
    '{2'b00,1'b0,11'd1023,1'b1,52'h1,2'b10,11'd1023,52'h2,1'b1,1'b0,8'd1},     // R1 tie, odd bumped
    '{2'b00,1'b1,11'd1023,1'b1,52'h0,2'b11,11'd1023,52'h1,1'b1,1'b0,8'd1},     // R1 above half
    '{2'b00,1'b0,11'd1023,1'b1,52'h5,2'b01,11'd1023,52'h5,1'b1,1'b0,8'd1},     // R1 below half
    '{2'b01,1'b0,11'd500, 1'b1,ONES, 2'b11,11'd500, ONES, 1'b1,1'b0,8'd2},     // R2
    '{2'b10,1'b0,11'd700, 1'b1,52'h3,2'b01,11'd700, 52'h4,1'b1,1'b0,8'd3},     // R3 positive
    '{2'b10,1'b1,11'd700, 1'b1,52'h3,2'b11,11'd700, 52'h3,1'b1,1'b0,8'd3},     // R3 negative
    '{2'b11,1'b1,11'd300, 1'b1,52'h7,2'b01,11'd300, 52'h8,1'b1,1'b0,8'd4},     // R4 negative
    '{2'b11,1'b0,11'd300, 1'b1,52'h7,2'b10,11'd300, 52'h7,1'b1,1'b0,8'd4},     // R4 positive
    '{2'b00,1'b0,11'd1023,1'b1,52'h123,2'b00,11'd1023,52'h123,1'b0,1'b0,8'd7}, // R7 exact
    '{2'b00,1'b0,11'd1023,1'b1,ONES, 2'b11,11'd1024,52'h0,1'b1,1'b0,8'd5},     // R5 carry
    '{2'b00,1'b0,11'd0,   1'b0,ONES, 2'b11,11'd1,   52'h0,1'b1,1'b0,8'd6},     // R6 promote
    '{2'b00,1'b1,11'd0,   1'b0,52'h5,2'b10,11'd0,   52'h6,1'b1,1'b0,8'd6},     // R6 stays subnormal
    '{2'b00,1'b0,11'd2046,1'b1,ONES, 2'b11,11'd2047,52'h0,1'b1,1'b1,8'd8},     // R8 to +inf
    '{2'b11,1'b1,11'd2046,1'b1,ONES, 2'b01,11'd2047,52'h0,1'b1,1'b1,8'd8},     // R8 to -inf
    '{2'b01,1'b0,11'd2047,1'b1,52'h0,2'b00,11'd2046,ONES, 1'b1,1'b1,8'd9},     // R9 mode 01
    '{2'b10,1'b1,11'd2047,1'b1,52'h0,2'b00,11'd2046,ONES, 1'b1,1'b1,8'd9},     // R9 mode 10 neg
    '{2'b11,1'b0,11'd2047,1'b1,52'h9,2'b10,11'd2046,ONES, 1'b1,1'b1,8'd9}      // R9 mode 11 pos
  };

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] m, input logic s,
                       input logic [10:0] e, input logic ld, input logic [51:0] f,
                       input logic [1:0] gs);
    in_valid = v;
    in_mode  = m;
    in_sign  = s;
    in_exp   = e;
    in_mant  = {1'b0, ld, f, gs};
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk("R10", "reset valid", {63'd0, out_valid}, 64'd0);
    chk("R10", "reset result", out_result, 64'd0);
    chk("R10", "reset flags", {62'd0, out_inexact, out_overflow}, 64'd0);

    // Table walk: drive on falling edge, result due one rising edge later
    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VECS[i].req);
      drive(1'b1, VECS[i].mode, VECS[i].sign, VECS[i].exp, VECS[i].lead,
            VECS[i].frac, VECS[i].gs);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R10", "valid", {63'd0, out_valid}, 64'd1);
      chk(rq, "result", out_result, {VECS[i].sign, VECS[i].e_exp, VECS[i].e_frac});
      chk("R7", "inexact", {63'd0, out_inexact}, {63'd0, VECS[i].e_ix});
      chk(rq, "overflow", {63'd0, out_overflow}, {63'd0, VECS[i].e_ov});
    end

    // R10: idle input with new data must not disturb the held result
    drive(1'b0, 2'b00, 1'b1, 11'd5, 1'b1, 52'hABC, 2'b11);
    @(posedge clk);
    @(negedge clk);
    chk("R10", "idle valid", {63'd0, out_valid}, 64'd0);
    chk("R10", "idle hold", out_result, {1'b0, 11'd2046, ONES});

    // R11 / R1: back-to-back inputs land on consecutive cycles
    drive(1'b1, 2'b00, 1'b1, 11'd10, 1'b1, 52'h1, 2'b10);
    @(posedge clk);
    @(negedge clk);
    drive(1'b1, 2'b01, 1'b0, 11'd20, 1'b1, 52'h2, 2'b11);
    chk("R11", "stream first", out_result, {1'b1, 11'd10, 52'h2});
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", "stream second", out_result, {1'b0, 11'd20, 52'h2});
    chk("R10", "stream valid", {63'd0, out_valid}, 64'd1);

    // R10: reset in the middle clears outputs
    drive(1'b1, 2'b00, 1'b0, 11'd1, 1'b1, 52'h1, 2'b11);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    chk("R10", "mid reset result", out_result, 64'd0);
    chk("R10", "mid reset valid", {63'd0, out_valid}, 64'd0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule